// File: doc/BRIEF.md
# Oversampled Manchester Receiver with Start-Bit Framing

This block takes a Manchester-coded serial line, sampled by a local clock that runs at about eight times the bit rate, and recovers the bit stream from it. Each recovered bit is presented on a one-cycle strobe together with its value. The decoder re-centres on every mid-cell transition. A small amount of frequency error between the transmitter and the receive clock is therefore absorbed cell by cell, and the block needs no phase-locked clock.

On top of the bit stream, a framer finds 16-bit words. A frame is a run of zero bits, a single 1 that marks the start, and then sixteen data bits, most significant first. The start bit is shifted into a chain together with the data that follows it. When it has travelled the length of the chain, the whole word is copied into a parallel output register. A one-cycle valid pulse is raised, the ready flag is set and the chain is emptied. The line input is asynchronous and is synchronised inside the block.

Top module: `mdec_rx`

## Requirements
- R1: During and right after reset, `bit_stb_o`, `bit_o`, `word_o`, `word_valid_o` and `word_ready_o` are all 0.
- R2: The cell encoding is: a 0 is high for the first half and low for the second half, and a 1 is low then high. Each cell of an unbroken stream produces exactly one strobe carrying that cell's value, in transmission order.
- R3: Half-cell lengths anywhere from 3 to 5 receive clocks, which models transmitter frequency error, cause no bit error and no lost or extra strobe.
- R4: Once in lock, a line transition less than GUARD (6) receive clocks after the last accepted centre transition is ignored. A one-clock pulse at a cell boundary therefore does not disturb decoding.
- R5: Out of lock, only a falling transition is accepted as a cell centre. Lock is lost after reset, or after 12 receive clocks without an accepted centre. A zero preamble thus locks in the correct phase whether the idle line was high or low.
- R6: `bit_stb_o` is one cycle wide, and two strobes are always at least GUARD cycles apart.
- R7: While the chain is empty, a strobed 1 is taken as a start bit, and `word_ready_o` is 0 in the cycle after that strobe.
- R8: In the cycle after the strobe of the 16th data bit following a start bit, `word_valid_o` is high for one cycle. In that cycle `word_o` holds the data bits with the first received bit in bit 15, and `word_ready_o` is 1.
- R9: The chain is emptied when a word is loaded. A start bit that follows the last data bit directly, with no zeros in between, is still found, and so are frames with 18 or more preamble zeros.
- R10: `word_o` changes only in a cycle where `word_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock, about 8x the bit rate |
| rst_ni | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Manchester line, asynchronous to clk_i |
| bit_o | output | 1 | Value of the most recently recovered bit |
| bit_stb_o | output | 1 | One-cycle strobe marking a recovered bit |
| word_o | output | WORD_W | Last complete word, first received bit in the MSB |
| word_valid_o | output | 1 | One-cycle pulse when word_o is loaded |
| word_ready_o | output | 1 | High from a word load until the next start bit |

## Verification
Two things fall in the same cycle here: the strobe of the last data bit of a frame must be shifted into the word, and that same strobe must load the output register and empty the chain. Running them together is what lets a start bit that arrives directly after the frame be found at all. The bench provokes this with words whose final bit is 0 and words whose final bit is 1, and sends frames back to back with no preamble zeros between them. It judges the result cycle by cycle: the valid pulse and the loaded word must appear one cycle after that strobe, and the following start bit must drop the ready flag one cycle after its own strobe.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   // One recovered bit: strobe plus value
   typedef struct packed {
      logic stb;
      logic val;
   } mdec_bit_t;

   // Width of a saturating counter that must hold the value lim
   function automatic int unsigned mdec_cnt_w(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic line_o,
   output logic line_q_o
);

   logic [STAGES-1:0] st;
   logic              prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (!rst_ni) st[g] <= 1'b0;
            else         st[g] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (!rst_ni) st[g] <= 1'b0;
            else         st[g] <= st[g-1];
         end
      end
   end

   // one more flop gives the previous level for edge detection
   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev <= 1'b0;
      else         prev <= st[STAGES-1];
   end

   assign line_o   = st[STAGES-1];
   assign line_q_o = prev;

endmodule

// File: rtl/mdec_bit_dec.sv
module mdec_bit_dec
   import mdec_pkg::*;
#(
   parameter int unsigned GUARD      = 6,
   parameter int unsigned SAMPLE_DLY = 2,
   parameter int unsigned LOST_LIM   = 12
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      line_i,
   input  logic      line_q_i,
   output mdec_bit_t bit_o
);

   localparam int unsigned CW = mdec_cnt_w(LOST_LIM);
   localparam logic [CW-1:0] LIM_C   = CW'(LOST_LIM);
   localparam logic [CW-1:0] GUARD_C = CW'(GUARD - 1);
   localparam logic [CW-1:0] SMP_C   = CW'(SAMPLE_DLY - 1);

   // cnt + 1 is the distance in clocks from the last accepted centre
   logic [CW-1:0] cnt;
   logic          locked;
   logic          pend;
   logic          rise, fall, accept;

   assign rise   = line_i & ~line_q_i;
   assign fall   = ~line_i & line_q_i;
   assign accept = locked ? ((rise | fall) && (cnt >= GUARD_C)) : fall;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt    <= LIM_C;
         locked <= 1'b0;
         pend   <= 1'b0;
         bit_o  <= '0;
      end else begin
         bit_o.stb <= 1'b0;
         if (pend && (cnt == SMP_C)) begin
            bit_o.stb <= 1'b1;
            bit_o.val <= line_i;
            pend      <= 1'b0;
         end
         if (accept) begin
            cnt    <= '0;
            locked <= 1'b1;
            pend   <= 1'b1;
         end else begin
            if (cnt != LIM_C) cnt <= cnt + 1'b1;
            if (cnt == LIM_C) locked <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mdec_framer.sv
module mdec_framer
   import mdec_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  mdec_bit_t         bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              ready_o
);

   // shift chain; a set top bit means the start bit has one place left
   logic [WORD_W-1:0] chain;
   logic [WORD_W-1:0] shifted;
   logic              empty;

   assign shifted = {chain[WORD_W-2:0], bit_i.val};
   assign empty   = (chain == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chain   <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
         ready_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (bit_i.stb) begin
            if (chain[WORD_W-1]) begin
               // last data bit: load, flag and empty the chain in one step
               word_o  <= shifted;
               valid_o <= 1'b1;
               ready_o <= 1'b1;
               chain   <= '0;
            end else begin
               if (empty && bit_i.val) ready_o <= 1'b0;
               chain <= shifted;
            end
         end
      end
   end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
   import mdec_pkg::*;
#(
   parameter int unsigned OVS         = 8,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SAMPLE_DLY  = 2,
   parameter int unsigned GUARD       = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_i,
   output logic              bit_o,
   output logic              bit_stb_o,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o,
   output logic              word_ready_o
);

   localparam int unsigned LOST_LIM = OVS + OVS / 2;

   if (OVS < 4) begin : g_bad_ovs
      $error("mdec_rx: OVS must be at least 4");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("mdec_rx: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mdec_rx: SYNC_STAGES must be at least 2");
   end
   if ((GUARD <= OVS / 2) || (GUARD >= OVS)) begin : g_bad_guard
      $error("mdec_rx: GUARD must lie between OVS/2 and OVS");
   end
   if ((SAMPLE_DLY < 1) || (SAMPLE_DLY >= OVS / 2)) begin : g_bad_smp
      $error("mdec_rx: SAMPLE_DLY must lie inside the second half cell");
   end

   logic      line_s, line_sq;
   mdec_bit_t rx_bit;

   mdec_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_i),
      .line_o  (line_s),
      .line_q_o(line_sq)
   );

   mdec_bit_dec #(
      .GUARD     (GUARD),
      .SAMPLE_DLY(SAMPLE_DLY),
      .LOST_LIM  (LOST_LIM)
   ) i_bit_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_s),
      .line_q_i(line_sq),
      .bit_o   (rx_bit)
   );

   mdec_framer #(.WORD_W(WORD_W)) i_framer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (rx_bit),
      .word_o (word_o),
      .valid_o(word_valid_o),
      .ready_o(word_ready_o)
   );

   assign bit_o     = rx_bit.val;
   assign bit_stb_o = rx_bit.stb;

endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned GUARD  = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bit_o,
   input logic              bit_stb_o,
   input logic [WORD_W-1:0] word_o,
   input logic              word_valid_o,
   input logic              word_ready_o
);

   localparam int unsigned GW = $clog2(GUARD + 1);
   localparam logic [GW-1:0] GSAT = GW'(GUARD);

   // clocks since the last strobe, saturating at GUARD
   logic [GW-1:0] gap;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)          gap <= GSAT;
      else if (bit_stb_o)   gap <= GW'(1);
      else if (gap != GSAT) gap <= gap + 1'b1;
   end

   AST_STB_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_stb_o |-> (gap >= GSAT)); // R6

   AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_stb_o |=> !bit_stb_o); // R6

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_valid_o |=> !word_valid_o); // R8

   AST_VALID_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_valid_o |-> $past(bit_stb_o)); // R8

   AST_READY_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_valid_o |-> word_ready_o); // R8

   AST_READY_DROP_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(word_ready_o) |-> $past(bit_stb_o && bit_o)); // R7

   AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(word_o) |-> word_valid_o); // R10

endmodule

bind mdec_rx mdec_rx_chk #(.WORD_W(WORD_W), .GUARD(GUARD)) i_mdec_rx_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bit_o       (bit_o),
   .bit_stb_o   (bit_stb_o),
   .word_o      (word_o),
   .word_valid_o(word_valid_o),
   .word_ready_o(word_ready_o)
);

// File: tb/test_mdec_rx.sv
`timescale 1ns/1ps
module test_mdec_rx;

   localparam int MAXB = 4096;

   logic        clk = 1'b0;
   logic        rst_ni;
   logic        line;
   logic        bit_v, bit_stb, word_valid, word_ready;
   logic [15:0] word;

   always #2.5 clk = ~clk;

   mdec_rx i_mdec_rx (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .line_i      (line),
      .bit_o       (bit_v),
      .bit_stb_o   (bit_stb),
      .word_o      (word),
      .word_valid_o(word_valid),
      .word_ready_o(word_ready)
   );

   int          checks = 0, errors = 0;
   int          nb = 0, got = 0, words_exp = 0, words_got = 0;
   logic        exp_bit   [MAXB];
   bit          is_start  [MAXB];
   bit          is_last   [MAXB];
   logic [15:0] exp_word  [MAXB];
   string       tag = "R2";
   int          h_lo = 4, h_hi = 4;
   logic        last_b = 1'b0;
   bit          mon_on = 1'b0;
   bit          pend_valid = 1'b0, pend_rdy = 1'b0;
   logic [15:0] pend_word;
   int          cyc = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   function automatic int half_len();
      return h_lo + int'($urandom % (h_hi - h_lo + 1));
   endfunction

   function automatic logic [15:0] rand_word();
      return 16'($urandom);
   endfunction

   // first clock of the half optionally inverted to make a one-clock pulse
   task automatic send_half(input logic lvl, input int len, input bit glitch);
      line = glitch ? ~lvl : lvl;
      @(negedge clk);
      line = lvl;
      repeat (len - 1) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      exp_bit[nb]  = b;
      is_start[nb] = 1'b0;
      is_last[nb]  = 1'b0;
      nb++;
      send_half(~b, half_len(), glitch && b && !last_b);
      send_half(b, half_len(), 1'b0);
      last_b = b;
   endtask

   task automatic send_frame(input int pre, input logic [15:0] w, input bit glitch);
      for (int i = 0; i < pre; i++) send_bit(1'b0, 1'b0);
      is_start[nb] = 1'b1;
      send_bit(1'b1, glitch);
      is_start[nb-1] = 1'b1;
      for (int i = 15; i >= 0; i--) send_bit(w[i], glitch);
      is_last[nb-1]  = 1'b1;
      exp_word[nb-1] = w;
      words_exp++;
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         finish_run();
      end
   end

   // monitor, samples away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (pend_rdy) begin
            check(word_ready == 1'b0, "R7", "ready after start", word_ready, 0);
            pend_rdy = 1'b0;
         end
         if (pend_valid) begin
            check(word_valid == 1'b1, "R8", "valid after last bit", word_valid, 1);
            check(word == pend_word, "R8", "loaded word", word, pend_word);
            check(word_ready == 1'b1, "R8", "ready at load", word_ready, 1);
            if (word_valid) words_got++;
            pend_valid = 1'b0;
         end else if (word_valid) begin
            check(1'b0, "R8", "unexpected valid", 1, 0);
         end
         if (bit_stb) begin
            if (got < nb) begin
               check(bit_v == exp_bit[got], tag, "decoded bit", bit_v, exp_bit[got]);
               if (is_start[got]) pend_rdy = 1'b1;
               if (is_last[got]) begin
                  pend_valid = 1'b1;
                  pend_word  = exp_word[got];
               end
            end else begin
               check(1'b0, tag, "extra strobe", got, nb);
            end
            got++;
         end
      end
   end

   initial begin
      line   = 1'b1;
      rst_ni = 1'b0;
      repeat (5) @(negedge clk);
      check({bit_stb, bit_v, word_valid, word_ready} == 4'b0, "R1", "outputs in reset",
            {bit_stb, bit_v, word_valid, word_ready}, 0);
      check(word == 16'h0, "R1", "word in reset", word, 0);
      rst_ni = 1'b1;
      @(negedge clk);
      check({bit_stb, word_valid, word_ready} == 3'b0, "R1", "outputs after reset",
            {bit_stb, word_valid, word_ready}, 0);
      check(word == 16'h0, "R1", "word after reset", word, 0);
      mon_on = 1'b1;

      // R2: nominal timing, directed patterns, last bit both 0 and 1
      tag = "R2";
      send_frame(31, 16'hA5C3, 1'b0);
      send_frame(18, 16'h0000, 1'b0);
      send_frame(18, 16'hFFFF, 1'b0);
      send_frame(20, 16'h8001, 1'b0);

      // R9: start bit straight after the last data bit
      tag = "R9";
      send_frame(18, 16'h1234, 1'b0);
      send_frame(0, 16'h00FF, 1'b0);
      send_frame(0, 16'hFFFE, 1'b0);
      send_frame(0, 16'h7FFF, 1'b0);

      // R4: one-clock pulses at boundaries before each 1 that follows a 0
      tag = "R4";
      send_frame(20, 16'h5555, 1'b1);
      send_frame(18, 16'h2DB4, 1'b1);

      // R3: random half-cell lengths 3..5 and random words
      tag = "R3";
      h_lo = 3; h_hi = 5;
      for (int i = 0; i < 12; i++) send_frame(18 + int'($urandom % 14), rand_word(), 1'b0);
      h_lo = 4; h_hi = 4;

      // R5: lock lost on an idle low line, then reacquired on a falling centre
      tag = "R5";
      line = 1'b0;
      repeat (40) @(negedge clk);
      send_frame(25, 16'hC00C, 1'b0);
      line = 1'b1;
      repeat (40) @(negedge clk);
      send_frame(18, 16'h7E81, 1'b0);

      line = 1'b1;
      repeat (60) @(negedge clk);
      check(got == nb, "R2", "strobe count", got, nb);
      check(words_got == words_exp, "R8", "word count", words_got, words_exp);
      check(word_ready == 1'b1, "R8", "ready at idle", word_ready, 1);
      finish_run();
   end

endmodule